// File: doc/BRIEF.md
# Reloading 16-bit Down-Counter Timer

This block is a periodic timer that sits on a simple word-wide register bus. Software places a 16-bit period in the reload register and sets the run bit in the control register. From then on, a 16-bit counter steps down once per microsecond. When it reaches zero, it takes the reload value again on the next tick, so it runs forever. A prescaler divides the system clock down to a one-cycle tick enable at 1 MHz. Its ratio comes from the parameters `CLK_HZ` and `TICK_HZ`.

The bus is a plain strobe interface, not a stream. Every access finishes in a single cycle, so there is no valid/ready pair and no back-pressure. A write takes effect on the clock edge at which `bus_wr` is sampled high. Read data appears on `bus_rdata` one cycle after the `bus_rd` strobe. The window is 256 bytes, and only whole aligned 32-bit words are decoded.

Register map:
- Offset 0x00 holds the control word. Bit 0 is the run bit and bit 31 is the clear bit.
- Offset 0x08 holds the reload value.
- Offset 0x0C holds the live count.

Once the counter has started, only the clear bit or the reset pin stops it.

Top module: `tmr16_top`

## Requirements
- R1: After `rst_n` is released, reads of offsets 0x00, 0x08 and 0x0C all return 0. The count then stays 0 with no further accesses, because the counter is stopped.
- R2: Only the exact byte addresses 0x00 (control), 0x08 (reload) and 0x0C (count) are decoded. Any other address, including one that is not a multiple of 4, reads as 0, and a write to it changes no register.
- R3: `bus_rdata` is registered. It carries the selected register in the cycle after a cycle with `bus_rd` high, and is 0 in the cycle after a cycle with `bus_rd` low.
- R4: A write to offset 0x08 keeps only bits [15:0]. That value reads back from 0x08 with bits [31:16] zero, and it is copied into the live count on the same edge, whether the counter is running or stopped.
- R5: A read of offset 0x0C returns the live count in bits [15:0] with bits [31:16] zero. A write to 0x0C changes nothing.
- R6: A control write with bit 31 set stores nothing. Instead it sets control, reload and count to 0 and stops the counter, even when bit 0 of the same word is set.
- R7: A control write with bit 31 clear stores the whole 32-bit word. If bit 0 is also set, that write starts the counter and restarts the prescaler phase, including when the counter was already running.
- R8: A control write with bit 0 clear does not stop a running counter.
- R9: While the counter runs, a tick occurs every `CLK_HZ/TICK_HZ` clock cycles, and never on two adjacent cycles. The first tick after a start moves the count `CLK_HZ/TICK_HZ` cycles after the start edge.
- R10: On a tick, a non-zero count decreases by one and a zero count takes the reload value. With a reload value of 0, the count stays at 0.
- R11: When a reload write and a tick fall on the same edge, the written value becomes the count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, `CLK_HZ` Hz |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_addr | input | 8 | Byte address within the 256-byte window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data, valid one cycle after `bus_rd` |

## Verification
The properties assume the following about the bus inputs:
- Each strobe is a known level after reset.
- `bus_addr` and `bus_wdata` are meaningful only in a cycle whose strobe is high.
- A write is a single-cycle event, so "the following edge" always refers to the edge after that one write.

The stimulus respects these limits:
- Strobes and data are driven only on falling edges.
- Each strobe is held for exactly one cycle.
- Address and data return to zero between accesses.
- Read and write are never raised together.

Count samples are timed in the middle of a tick period, except where a test aims a write exactly at a tick edge.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;

  // Bus word width and the fixed register offsets.
  localparam int unsigned BUS_W      = 32;
  localparam int unsigned OFS_CTRL   = 'h00;
  localparam int unsigned OFS_RELOAD = 'h08;
  localparam int unsigned OFS_COUNT  = 'h0C;

  // Control word bit positions.
  localparam int unsigned CTRL_RUN_BIT = 0;
  localparam int unsigned CTRL_CLR_BIT = 31;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_CTRL,
    SEL_RELOAD,
    SEL_COUNT
  } reg_sel_e;

endpackage

// File: rtl/tmr16_decode.sv
module tmr16_decode
  import tmr16_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr_i,
  output reg_sel_e          sel_o
);

  // Exact compare: unaligned byte addresses fall through to SEL_NONE.
  always_comb begin
    if (addr_i == ADDR_W'(OFS_CTRL))        sel_o = SEL_CTRL;
    else if (addr_i == ADDR_W'(OFS_RELOAD)) sel_o = SEL_RELOAD;
    else if (addr_i == ADDR_W'(OFS_COUNT))  sel_o = SEL_COUNT;
    else                                    sel_o = SEL_NONE;
  end

endmodule

// File: rtl/tmr16_prescaler.sv
module tmr16_prescaler #(
  parameter int unsigned DIV = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic restart_i,
  output logic tick_o
);

  generate
    if (DIV <= 1) begin : g_bypass
      // Clock already at tick rate: every running cycle is a tick.
      assign tick_o = run_i && !restart_i;
    end else begin : g_div
      localparam int unsigned PW = $clog2(DIV);
      localparam logic [PW-1:0] LAST = PW'(DIV - 1);

      logic [PW-1:0] phase_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          phase_q <= '0;
        end else if (!run_i || restart_i) begin
          phase_q <= '0;
        end else if (phase_q == LAST) begin
          phase_q <= '0;
        end else begin
          phase_q <= phase_q + 1'b1;
        end
      end

      assign tick_o = run_i && !restart_i && (phase_q == LAST);
    end
  endgenerate

endmodule

// File: rtl/tmr16_counter.sv
module tmr16_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic [CNT_W-1:0] count_o
);

  logic [CNT_W-1:0] count_q;

  // Priority: clear, then software load, then tick.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
    end else if (clear_i) begin
      count_q <= '0;
    end else if (load_i) begin
      count_q <= load_val_i;
    end else if (tick_i) begin
      if (count_q == '0) count_q <= reload_i;
      else               count_q <= count_q - 1'b1;
    end
  end

  assign count_o = count_q;

endmodule

// File: rtl/tmr16_regs.sv
module tmr16_regs
  import tmr16_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic             rd_i,
  input  reg_sel_e         sel_i,
  input  logic [BUS_W-1:0] wdata_i,
  input  logic [CNT_W-1:0] count_i,
  output logic [BUS_W-1:0] ctrl_o,
  output logic [CNT_W-1:0] reload_o,
  output logic             running_o,
  output logic             start_o,
  output logic             clear_o,
  output logic             load_o,
  output logic [BUS_W-1:0] rdata_o
);

  localparam int unsigned PAD_W = BUS_W - CNT_W;

  logic             wr_ctrl;
  logic [BUS_W-1:0] ctrl_q;
  logic [CNT_W-1:0] reload_q;
  logic             running_q;
  logic [BUS_W-1:0] rd_mux;
  logic [BUS_W-1:0] rdata_q;

  assign wr_ctrl = wr_i && (sel_i == SEL_CTRL);
  assign clear_o = wr_ctrl && wdata_i[CTRL_CLR_BIT];
  assign start_o = wr_ctrl && !wdata_i[CTRL_CLR_BIT] && wdata_i[CTRL_RUN_BIT];
  assign load_o  = wr_i && (sel_i == SEL_RELOAD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      reload_q  <= '0;
      running_q <= 1'b0;
    end else if (clear_o) begin
      ctrl_q    <= '0;
      reload_q  <= '0;
      running_q <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl_q <= wdata_i;
      if (start_o) running_q <= 1'b1;
      if (load_o)  reload_q <= wdata_i[CNT_W-1:0];
    end
  end

  always_comb begin
    unique case (sel_i)
      SEL_CTRL:   rd_mux = ctrl_q;
      SEL_RELOAD: rd_mux = {{PAD_W{1'b0}}, reload_q};
      SEL_COUNT:  rd_mux = {{PAD_W{1'b0}}, count_i};
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= rd_i ? rd_mux : '0;
  end

  assign ctrl_o    = ctrl_q;
  assign reload_o  = reload_q;
  assign running_o = running_q;
  assign rdata_o   = rdata_q;

endmodule

// File: rtl/tmr16_top.sv
module tmr16_top
  import tmr16_pkg::*;
#(
  parameter int unsigned CLK_HZ  = 50_000_000,
  parameter int unsigned TICK_HZ = 1_000_000,
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned CNT_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata
);

  localparam int unsigned DIV = CLK_HZ / TICK_HZ;

  reg_sel_e         sel;
  logic [BUS_W-1:0] ctrl_w;
  logic [CNT_W-1:0] reload_w;
  logic [CNT_W-1:0] count_w;
  logic             running_w;
  logic             start_w;
  logic             clear_w;
  logic             load_w;
  logic             tick_w;

  tmr16_decode #(.ADDR_W(ADDR_W)) u_decode (
    .addr_i (bus_addr),
    .sel_o  (sel)
  );

  tmr16_regs #(.CNT_W(CNT_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_i      (bus_wr),
    .rd_i      (bus_rd),
    .sel_i     (sel),
    .wdata_i   (bus_wdata),
    .count_i   (count_w),
    .ctrl_o    (ctrl_w),
    .reload_o  (reload_w),
    .running_o (running_w),
    .start_o   (start_w),
    .clear_o   (clear_w),
    .load_o    (load_w),
    .rdata_o   (bus_rdata)
  );

  tmr16_prescaler #(.DIV(DIV)) u_presc (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_i     (running_w),
    .restart_i (start_w || clear_w),
    .tick_o    (tick_w)
  );

  tmr16_counter #(.CNT_W(CNT_W)) u_count (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear_i    (clear_w),
    .load_i     (load_w),
    .load_val_i (bus_wdata[CNT_W-1:0]),
    .tick_i     (tick_w),
    .reload_i   (reload_w),
    .count_o    (count_w)
  );

endmodule

// File: rtl/tmr16_checker.sv
module tmr16_checker
  import tmr16_pkg::*;
#(
  parameter int unsigned DIV    = 50,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned CNT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [CNT_W-1:0]  wdata_lo,
  input logic              wdata_clr,
  input logic [BUS_W-1:0]  bus_rdata,
  input logic [BUS_W-1:0]  ctrl,
  input logic [CNT_W-1:0]  reload,
  input logic [CNT_W-1:0]  count,
  input logic              running,
  input logic              tick
);

  logic at_ctrl, at_reload, at_count;
  assign at_ctrl   = (bus_addr == ADDR_W'(OFS_CTRL));
  assign at_reload = (bus_addr == ADDR_W'(OFS_RELOAD));
  assign at_count  = (bus_addr == ADDR_W'(OFS_COUNT));

  // R6: clear bit wipes state and stops the counter
  a_r6_soft_clear: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && at_ctrl && wdata_clr |=> ctrl == '0 && reload == '0 && count == '0 && !running);

  // R4: reload write lands in the live count
  a_r4_live_load: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && at_reload |=> count == $past(wdata_lo));

  // R5: count register ignores writes
  a_r5_count_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && at_count && !tick |=> $stable(count));

  // R5: count reads carry zero upper bits
  a_r5_count_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd && at_count |=> bus_rdata[BUS_W-1:CNT_W] == '0);

  // R2: undecoded writes leave the registers alone
  a_r2_undecoded_write: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && !at_ctrl && !at_reload && !at_count |=> $stable(ctrl) && $stable(reload));

  // R8: only the clear bit stops a running counter
  a_r8_run_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    running && !(bus_wr && at_ctrl && wdata_clr) |=> running);

  // R1: stopped counter holds its value without bus writes
  a_r1_stopped_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !running && !bus_wr |=> $stable(count));

  // R10: tick decrements a non-zero count
  a_r10_decrement: assert property (@(posedge clk) disable iff (!rst_n)
    tick && count != '0 && !bus_wr |=> count == $past(count) - CNT_W'(1));

  // R10: tick at zero takes the reload value
  a_r10_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    tick && count == '0 && !bus_wr |=> count == $past(reload));

  // R9: ticks never on adjacent cycles when dividing
  a_r9_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (DIV > 1) && tick |=> !tick);

  // R3: idle cycles return zero read data
  a_r3_idle_rdata: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> bus_rdata == '0);

endmodule

bind tmr16_top tmr16_checker #(.DIV(DIV), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_addr  (bus_addr),
  .wdata_lo  (bus_wdata[CNT_W-1:0]),
  .wdata_clr (bus_wdata[tmr16_pkg::CTRL_CLR_BIT]),
  .bus_rdata (bus_rdata),
  .ctrl      (ctrl_w),
  .reload    (reload_w),
  .count     (count_w),
  .running   (running_w),
  .tick      (tick_w)
);

// File: tb/sim_tmr16_top.sv
module sim_tmr16_top;

  localparam int unsigned CLK_HZ  = 50_000_000;
  localparam int unsigned TICK_HZ = 1_000_000;
  localparam int DIV  = CLK_HZ / TICK_HZ;
  localparam int HALF = DIV / 2;
  localparam int NVEC = 16;

  // {req[3:0], is_write, addr[7:0], data_or_expected[31:0]}
  localparam logic [44:0] VEC [NVEC] = '{
    {4'd4, 1'b1, 8'h08, 32'hABCD_1234},
    {4'd4, 1'b0, 8'h08, 32'h0000_1234},   // R4 upper bits dropped
    {4'd4, 1'b0, 8'h0C, 32'h0000_1234},   // R4 count loaded while stopped
    {4'd5, 1'b1, 8'h0C, 32'h0000_5555},
    {4'd5, 1'b0, 8'h0C, 32'h0000_1234},   // R5 count write ignored
    {4'd2, 1'b1, 8'h04, 32'hFFFF_FFFF},
    {4'd2, 1'b0, 8'h04, 32'h0000_0000},   // R2 hole reads zero
    {4'd2, 1'b1, 8'h09, 32'h0000_FFFF},
    {4'd2, 1'b0, 8'h08, 32'h0000_1234},   // R2 unaligned write ignored
    {4'd2, 1'b0, 8'h0D, 32'h0000_0000},   // R2 unaligned read zero
    {4'd7, 1'b1, 8'h00, 32'h7FFF_0006},
    {4'd7, 1'b0, 8'h00, 32'h7FFF_0006},   // R7 full word stored
    {4'd7, 1'b0, 8'h0C, 32'h0000_1234},   // R7 no run bit, no start
    {4'd2, 1'b0, 8'hFC, 32'h0000_0000},   // R2 top of window
    {4'd6, 1'b1, 8'h00, 32'h8000_0000},
    {4'd6, 1'b0, 8'h08, 32'h0000_0000}    // R6 reload cleared
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  tmr16_top #(.CLK_HZ(CLK_HZ), .TICK_HZ(TICK_HZ)) u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
  endtask

  task automatic read_check(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0; bus_addr = '0;
    check(tag, bus_rdata, exp);
  endtask

  task automatic wait_until(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int s;
    int s2;
    int s3;
    logic [31:0] seq [6] = '{32'd3, 32'd2, 32'd1, 32'd0, 32'd3, 32'd2};

    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    read_check(8'h00, 32'h0, "R1 ctrl after reset");
    read_check(8'h08, 32'h0, "R1 reload after reset");
    read_check(8'h0C, 32'h0, "R1 count after reset");
    repeat (2 * DIV) @(negedge clk);
    read_check(8'h0C, 32'h0, "R1 count stays stopped");

    // Vector table
    for (int i = 0; i < NVEC; i++) begin
      automatic logic [44:0] v = VEC[i];
      if (v[40]) bus_write(v[39:32], v[31:0]);
      else read_check(v[39:32], v[31:0], $sformatf("R%0d vector %0d", v[44:41], i));
    end

    // R9 R10 periodic countdown with wrap
    bus_write(8'h08, 32'd3);
    bus_write(8'h00, 32'd1);
    s = cyc;
    for (int j = 0; j < 6; j++) begin
      wait_until(s + HALF + DIV * j);
      read_check(8'h0C, seq[j], $sformatf("R9 R10 period %0d", j));
    end

    // R8 clearing the run bit keeps counting
    bus_write(8'h00, 32'd0);
    read_check(8'h00, 32'd0, "R8 ctrl cleared");
    wait_until(s + HALF + DIV * 6);
    read_check(8'h0C, 32'd1, "R8 still running");
    wait_until(s + HALF + DIV * 7);
    read_check(8'h0C, 32'd0, "R8 still running");

    // R11 reload write on a tick edge wins
    wait_until(s + DIV * 8 - 2);
    bus_write(8'h08, 32'd40);
    read_check(8'h0C, 32'd40, "R11 write beats tick");
    @(negedge clk);
    check("R3 idle rdata", bus_rdata, 32'h0);
    wait_until(s + HALF + DIV * 9);
    read_check(8'h0C, 32'd39, "R4 live reload keeps phase");

    // R7 restart clears prescaler phase
    wait_until(s + DIV * 10 + 8);
    bus_write(8'h00, 32'd1);
    s2 = cyc;
    wait_until(s2 + 43);
    read_check(8'h0C, 32'd38, "R7 phase restarted");
    wait_until(s2 + HALF + DIV);
    read_check(8'h0C, 32'd37, "R7 first tick after restart");

    // R6 clear bit with run bit set
    bus_write(8'h00, 32'h8000_0001);
    read_check(8'h00, 32'h0, "R6 ctrl not stored");
    read_check(8'h08, 32'h0, "R6 reload cleared");
    read_check(8'h0C, 32'h0, "R6 count cleared");
    repeat (3 * DIV) @(negedge clk);
    read_check(8'h0C, 32'h0, "R6 stopped");
    bus_write(8'h08, 32'd5);
    repeat (3 * DIV) @(negedge clk);
    read_check(8'h0C, 32'd5, "R6 stopped after load");

    // R10 reload of one, then zero reload holds zero
    bus_write(8'h08, 32'd1);
    bus_write(8'h00, 32'd1);
    s3 = cyc;
    wait_until(s3 + HALF);
    read_check(8'h0C, 32'd1, "R10 reload one");
    wait_until(s3 + HALF + DIV);
    read_check(8'h0C, 32'd0, "R10 reload one");
    wait_until(s3 + HALF + 2 * DIV);
    read_check(8'h0C, 32'd1, "R10 wrap to one");
    bus_write(8'h08, 32'd0);
    wait_until(s3 + HALF + 4 * DIV);
    read_check(8'h0C, 32'd0, "R10 zero reload");
    wait_until(s3 + HALF + 5 * DIV);
    read_check(8'h0C, 32'd0, "R10 zero reload");

    // R1 pin reset while running
    bus_write(8'h08, 32'd9);
    bus_write(8'h00, 32'd1);
    repeat (DIV + 7) @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    read_check(8'h00, 32'h0, "R1 ctrl after pin reset");
    read_check(8'h08, 32'h0, "R1 reload after pin reset");
    read_check(8'h0C, 32'h0, "R1 count after pin reset");
    repeat (2 * DIV) @(negedge clk);
    read_check(8'h0C, 32'h0, "R1 stopped after pin reset");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule